// File: doc/BRIEF.md
# Program Counter Sequencer with Call Stack

This block sequences the 16-bit program address of a small controller whose program memory is split into pages. The controller sees one instruction at a time. Each accepted instruction class moves the program counter in one of several ways. It can step by one. It can load a spliced target, where the upper two bits come from a page register and the lower fourteen bits from the instruction. It can take an address from a hardware return stack. Or it can step by two when the ALU asks for the next instruction to be skipped. A return from an interrupt also turns on the global interrupt enable.

Branches, calls, returns and taken skips each cost one extra cycle. The block shows this by dropping `ready` for that cycle, and it ignores any instruction offered while `ready` is low. The block also holds a single save slot for the accumulator and the status byte. A save instruction fills the slot. A restore instruction gives the saved values back one cycle later, except that the timeout and power-down status bits keep their live values.

Top module: `pc_sequencer`

## Requirements
- R1: During and right after reset, `pc` is 0, `ready` is 1, `stk_ptr` and `stk_count` are 0, `stk_overflow`, `gie` and `restore_vld` are 0, and both restore outputs are 0.
- R2: An accepted instruction (`issue` and `ready`) of class 0 without `skip_req`, or of class 5, 6 or 7, sets `pc` to the old `pc` + 1 (modulo 2^16) at the next edge and leaves `ready` at 1.
- R3: An accepted class 1 (jump) sets `pc` to {`rom_page`, `target`} at the next edge and holds `ready` low for exactly the following cycle.
- R4: An accepted class 2 (call) pushes the old `pc` + 1 onto the stack and loads `pc` as a jump does, with one cycle of `ready` low.
- R5: An accepted class 3 (return) loads `pc` with the most recently pushed entry and pops it, with one cycle of `ready` low. Nested calls return in last-in first-out order.
- R6: An accepted class 4 (return from interrupt) behaves as a return and also sets `gie` to 1. Only reset clears `gie`.
- R7: An accepted class 0 with `skip_req` high sets `pc` to the old `pc` + 2 and holds `ready` low for one cycle. `skip_req` has no effect with any other class.
- R8: While `ready` is low, `issue` and all other instruction inputs are ignored. `pc`, the stack, `gie` and the save slot do not change, and `ready` returns to 1 at the next edge.
- R9: The stack holds 8 entries. `stk_ptr` wraps modulo 8 on both push and pop. `stk_count` counts up to 8 and never goes below 0. A return on an empty stack still moves the pointer back one place and loads the entry found there.
- R10: `stk_overflow` becomes 1 when a call is accepted while `stk_count` is 8. The call still writes over the oldest entry. The flag stays set until reset.
- R11: An accepted class 5 stores `acc_in` and `status_in`. One cycle after an accepted class 6, `restore_vld` is 1 for one cycle. `acc_restore` then carries the stored accumulator. `status_restore` carries the stored status, except that bits 4 (timeout) and 3 (power-down) carry `status_in` as it was in the restore cycle. The restore outputs hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An instruction is offered this cycle |
| op | input | 3 | Instruction class: 0 step, 1 jump, 2 call, 3 return, 4 interrupt return, 5 save, 6 restore, 7 step |
| target | input | 14 | Low address bits from the instruction |
| rom_page | input | 2 | Page register, becomes pc[15:14] on jump and call |
| skip_req | input | 1 | ALU asks for the next instruction to be skipped |
| acc_in | input | 8 | Live accumulator |
| status_in | input | 8 | Live status byte |
| ready | output | 1 | Low during the extra cycle of a branch or taken skip |
| pc | output | 16 | Program counter |
| stk_ptr | output | 3 | Stack write pointer |
| stk_count | output | 4 | Number of valid stack entries, 0 to 8 |
| stk_overflow | output | 1 | Sticky stack overflow |
| gie | output | 1 | Global interrupt enable |
| restore_vld | output | 1 | Restore outputs were updated this cycle |
| acc_restore | output | 8 | Restored accumulator |
| status_restore | output | 8 | Restored status with the protected bits merged in |

## Verification
The properties assume that the decoder drives `op`, `target`, `rom_page` and `skip_req` to known values whenever `issue` is high. They also assume that a return on an empty stack is legal and only reads whatever stale entry sits there. The stimulus keeps `issue` high through many bubble cycles, so the ignore rule is stressed. It pairs `skip_req` with classes that must not honour it, and it drives the stack both past full and below empty. All values come from known seeds or fixed patterns, never from undriven inputs.

// File: rtl/pc_seq_pkg.sv
// Package: shared instruction classes and decoded strobe bundle for the
// program counter sequencer. Assumes a 3-bit class code from the decoder.
package pc_seq_pkg;

    typedef enum logic [2:0] {
        CLS_STEP  = 3'd0,
        CLS_JUMP  = 3'd1,
        CLS_CALL  = 3'd2,
        CLS_RET   = 3'd3,
        CLS_IRET  = 3'd4,
        CLS_SAVE  = 3'd5,
        CLS_LOAD  = 3'd6,
        CLS_SPARE = 3'd7
    } cls_e;

    typedef struct packed {
        logic step;   // pc + 1
        logic skip;   // pc + 2, one bubble
        logic jump;   // spliced load, one bubble
        logic call;   // push then spliced load, one bubble
        logic ret;    // pop into pc, one bubble
        logic iret;   // pop into pc, set gie, one bubble
        logic save;   // capture accumulator and status
        logic load;   // present saved accumulator and status
    } strobe_t;

endpackage

// File: rtl/pc_seq_ctrl.sv
// Module: accepts one instruction per cycle, turns its class into one-hot
// strobes and inserts the single bubble cycle that branches and taken skips
// cost. Assumes op and skip_req are valid whenever issue is high.
module pc_seq_ctrl
    import pc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [2:0] op,
    input  logic       skip_req,
    output logic       ready,
    output strobe_t    stb
);

    logic bubble_q;
    logic bubble_d;
    logic accept;

    assign ready  = ~bubble_q;
    assign accept = issue & ~bubble_q;

    // Decode the accepted class into strobes; nothing fires during a bubble.
    always_comb begin
        stb = '0;
        if (accept) begin
            unique case (cls_e'(op))
                CLS_STEP:  if (skip_req) stb.skip = 1'b1;
                           else          stb.step = 1'b1;
                CLS_JUMP:  stb.jump = 1'b1;
                CLS_CALL:  stb.call = 1'b1;
                CLS_RET:   stb.ret  = 1'b1;
                CLS_IRET:  stb.iret = 1'b1;
                CLS_SAVE:  begin stb.save = 1'b1; stb.step = 1'b1; end
                CLS_LOAD:  begin stb.load = 1'b1; stb.step = 1'b1; end
                CLS_SPARE: stb.step = 1'b1;
                default:   stb.step = 1'b1;
            endcase
        end
    end

    // Two-cycle classes request exactly one bubble.
    assign bubble_d = stb.jump | stb.call | stb.ret | stb.iret | stb.skip;

    // Bubble register: set for one cycle after a two-cycle class.
    always_ff @(posedge clk) begin
        if (!rst_n) bubble_q <= 1'b0;
        else        bubble_q <= bubble_d;
    end

endmodule

// File: rtl/pc_call_stack.sv
// Module: return-address stack with a wrapping write pointer, a saturating
// occupancy count and a sticky overflow flag. Assumes push and pop are never
// raised together and that DEPTH is a power of two, at least 2.
module pc_call_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     top,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     ent [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] rd_idx;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign rd_idx   = ptr_q - PTR_W'(1);
    assign top      = ent[rd_idx];
    assign ptr      = ptr_q;
    assign count    = cnt_q;
    assign overflow = ovf_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Entry i: written by a push while the pointer addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                               ent[i] <= '0;
            else if (push && ptr_q == PTR_W'(i))      ent[i] <= wdata;
        end
    end

    // Pointer: wraps modulo DEPTH in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (push) ptr_q <= ptr_q + PTR_W'(1);
        else if (pop)  ptr_q <= rd_idx;
    end

    // Occupancy: saturates at DEPTH on push and at zero on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (push && cnt_q != FULL)    cnt_q <= cnt_q + CNT_W'(1);
        else if (pop && cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
    end

    // Overflow: set by a push into a full stack, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (push && cnt_q == FULL) ovf_q <= 1'b1;
    end

endmodule

// File: rtl/pc_shadow_regs.sv
// Module: single save slot for accumulator and status. A load presents the
// saved values one cycle later; bits set in PROT_MASK are taken from the
// live status instead. Assumes save and load are never raised together.
module pc_shadow_regs #(
    parameter int          DW        = 8,
    parameter logic [7:0]  PROT_MASK = 8'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save,
    input  logic          load,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] status_in,
    output logic          restore_vld,
    output logic [DW-1:0] acc_restore,
    output logic [DW-1:0] status_restore
);

    logic [DW-1:0] acc_sv;
    logic [DW-1:0] st_sv;
    logic [DW-1:0] st_merge;
    logic          vld_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] st_q;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b < 8 && PROT_MASK[b % 8]) begin : g_keep
            assign st_merge[b] = status_in[b];
        end else begin : g_restore
            assign st_merge[b] = st_sv[b];
        end
    end

    // Save slot: captured on a save instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sv <= '0;
            st_sv  <= '0;
        end else if (save) begin
            acc_sv <= acc_in;
            st_sv  <= status_in;
        end
    end

    // Restore outputs: updated and flagged for one cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            acc_q <= '0;
            st_q  <= '0;
        end else begin
            vld_q <= load;
            if (load) begin
                acc_q <= acc_sv;
                st_q  <= st_merge;
            end
        end
    end

    assign restore_vld    = vld_q;
    assign acc_restore    = acc_q;
    assign status_restore = st_q;

endmodule

// File: rtl/pc_sequencer.sv
// Module: program counter sequencer top. Holds the program counter and the
// global interrupt enable, and ties together the control, the return stack
// and the save slot. Assumes a single instruction per accepted cycle.
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 2,
    parameter int DEPTH  = 8,
    parameter int DW     = 8,
    parameter int TO_BIT = 4,
    parameter int PD_BIT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic [2:0]               op,
    input  logic [PC_W-PAGE_W-1:0]   target,
    input  logic [PAGE_W-1:0]        rom_page,
    input  logic                     skip_req,
    input  logic [DW-1:0]            acc_in,
    input  logic [DW-1:0]            status_in,
    output logic                     ready,
    output logic [PC_W-1:0]          pc,
    output logic [$clog2(DEPTH)-1:0] stk_ptr,
    output logic [$clog2(DEPTH):0]   stk_count,
    output logic                     stk_overflow,
    output logic                     gie,
    output logic                     restore_vld,
    output logic [DW-1:0]            acc_restore,
    output logic [DW-1:0]            status_restore
);

    localparam logic [7:0] PROT_MASK = 8'((1 << TO_BIT) | (1 << PD_BIT));

    strobe_t         stb;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] stk_top;
    logic            gie_q;

    pc_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .op       (op),
        .skip_req (skip_req),
        .ready    (ready),
        .stb      (stb)
    );

    assign pc_inc = pc_q + PC_W'(1);

    pc_call_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stb.call),
        .pop      (stb.ret | stb.iret),
        .wdata    (pc_inc),
        .top      (stk_top),
        .ptr      (stk_ptr),
        .count    (stk_count),
        .overflow (stk_overflow)
    );

    pc_shadow_regs #(.DW(DW), .PROT_MASK(PROT_MASK)) u_shadow (
        .clk            (clk),
        .rst_n          (rst_n),
        .save           (stb.save),
        .load           (stb.load),
        .acc_in         (acc_in),
        .status_in      (status_in),
        .restore_vld    (restore_vld),
        .acc_restore    (acc_restore),
        .status_restore (status_restore)
    );

    // Next program counter from the accepted strobe.
    always_comb begin
        pc_d = pc_q;
        if (stb.jump | stb.call)      pc_d = {rom_page, target};
        else if (stb.ret | stb.iret)  pc_d = stk_top;
        else if (stb.skip)            pc_d = pc_q + PC_W'(2);
        else if (stb.step)            pc_d = pc_inc;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Global interrupt enable: set by an interrupt return.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (stb.iret) gie_q <= 1'b1;
    end

    assign pc  = pc_q;
    assign gie = gie_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
// Checker: port-level timing properties of the program counter sequencer,
// bound to every instance of the top module.
module pc_sequencer_chk #(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 2,
    parameter int DEPTH  = 8,
    parameter int DW     = 8,
    parameter int TO_BIT = 4,
    parameter int PD_BIT = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue,
    input logic [2:0]               op,
    input logic [PC_W-PAGE_W-1:0]   target,
    input logic [PAGE_W-1:0]        rom_page,
    input logic                     skip_req,
    input logic [DW-1:0]            status_in,
    input logic                     ready,
    input logic [PC_W-1:0]          pc,
    input logic [$clog2(DEPTH)-1:0] stk_ptr,
    input logic [$clog2(DEPTH):0]   stk_count,
    input logic                     stk_overflow,
    input logic                     gie,
    input logic                     restore_vld,
    input logic [DW-1:0]            status_restore
);

    logic acc_ok;
    assign acc_ok = issue && ready;

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && ((op == 3'd0 && !skip_req) || op == 3'd5 || op == 3'd6 || op == 3'd7)
        |=> pc == $past(pc) + PC_W'(1) && ready);

    // R3
    jump_splice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd1 |=> pc == {$past(rom_page), $past(target)} && !ready);

    // R4
    call_splice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd2 |=> pc == {$past(rom_page), $past(target)} && !ready
                                 && stk_ptr == $past(stk_ptr) + 1'b1);

    // R5
    ret_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd3 |=> !ready && stk_ptr == $past(stk_ptr) - 1'b1);

    // R6
    iret_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd4 |=> gie && !ready);

    // R6
    gie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gie |=> gie);

    // R7
    skip_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd0 && skip_req |=> pc == $past(pc) + PC_W'(2) && !ready);

    // R8
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready && $stable(pc) && $stable(stk_ptr) && $stable(stk_count)
                   && !restore_vld);

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= ($clog2(DEPTH)+1)'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_overflow |=> stk_overflow);

    // R11
    restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 3'd6 |=> restore_vld);

    // R11
    protect_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_vld |-> status_restore[TO_BIT] == $past(status_in[TO_BIT])
                     && status_restore[PD_BIT] == $past(status_in[PD_BIT]));

endmodule

bind pc_sequencer pc_sequencer_chk #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH),
    .DW(DW), .TO_BIT(TO_BIT), .PD_BIT(PD_BIT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue          (issue),
    .op             (op),
    .target         (target),
    .rom_page       (rom_page),
    .skip_req       (skip_req),
    .status_in      (status_in),
    .ready          (ready),
    .pc             (pc),
    .stk_ptr        (stk_ptr),
    .stk_count      (stk_count),
    .stk_overflow   (stk_overflow),
    .gie            (gie),
    .restore_vld    (restore_vld),
    .status_restore (status_restore)
);

// File: tb/pc_sequencer_test.sv
// Bench: behavioural reference model compared against the sequencer on
// every clock. Inputs change on the falling edge, checks run there too.
module pc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  op = '0;
    logic [13:0] target = '0;
    logic [1:0]  rom_page = '0;
    logic        skip_req = 1'b0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  status_in = '0;
    logic        ready;
    logic [15:0] pc;
    logic [2:0]  stk_ptr;
    logic [3:0]  stk_count;
    logic        stk_overflow;
    logic        gie;
    logic        restore_vld;
    logic [7:0]  acc_restore;
    logic [7:0]  status_restore;

    always #2.5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .target(target),
        .rom_page(rom_page), .skip_req(skip_req), .acc_in(acc_in),
        .status_in(status_in), .ready(ready), .pc(pc), .stk_ptr(stk_ptr),
        .stk_count(stk_count), .stk_overflow(stk_overflow), .gie(gie),
        .restore_vld(restore_vld), .acc_restore(acc_restore),
        .status_restore(status_restore)
    );

    // Reference state
    int    m_pc, m_sp, m_cnt, m_racc, m_rst, m_sacc, m_sst;
    bit    m_ready, m_ovf, m_gie, m_rv;
    int    m_stk [8];
    int    vectors = 0;
    int    misses = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic model();
        bit take;
        int splice;
        if (!rst_n) begin
            m_pc = 0; m_sp = 0; m_cnt = 0; m_ready = 1; m_ovf = 0; m_gie = 0;
            m_rv = 0; m_racc = 0; m_rst = 0; m_sacc = 0; m_sst = 0;
            foreach (m_stk[i]) m_stk[i] = 0;
            return;
        end
        take = issue && m_ready;
        m_ready = 1;
        m_rv = 0;
        if (!take) return;
        splice = (int'(rom_page) << 14) | int'(target);
        case (int'(op))
            1: begin m_pc = splice; m_ready = 0; end
            2: begin
                m_stk[m_sp] = (m_pc + 1) & 16'hFFFF;
                m_sp = (m_sp + 1) % 8;
                if (m_cnt == 8) m_ovf = 1; else m_cnt++;
                m_pc = splice; m_ready = 0;
            end
            3, 4: begin
                m_sp = (m_sp + 7) % 8;
                m_pc = m_stk[m_sp];
                if (m_cnt > 0) m_cnt--;
                if (int'(op) == 4) m_gie = 1;
                m_ready = 0;
            end
            5: begin m_sacc = int'(acc_in); m_sst = int'(status_in); m_pc = (m_pc + 1) & 16'hFFFF; end
            6: begin
                m_rv = 1; m_racc = m_sacc;
                m_rst = (m_sst & 8'hE7) | (int'(status_in) & 8'h18);
                m_pc = (m_pc + 1) & 16'hFFFF;
            end
            0: begin
                if (skip_req) begin m_pc = (m_pc + 2) & 16'hFFFF; m_ready = 0; end
                else m_pc = (m_pc + 1) & 16'hFFFF;
            end
            default: m_pc = (m_pc + 1) & 16'hFFFF;
        endcase
    endtask

    task automatic chk(string f, int act, int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", cur_req, f, act, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("pc", int'(pc), m_pc);
        chk("ready", int'(ready), int'(m_ready));
        chk("stk_ptr", int'(stk_ptr), m_sp);
        chk("stk_count", int'(stk_count), m_cnt);
        chk("stk_overflow", int'(stk_overflow), int'(m_ovf));
        chk("gie", int'(gie), int'(m_gie));
        chk("restore_vld", int'(restore_vld), int'(m_rv));
        chk("acc_restore", int'(acc_restore), m_racc);
        chk("status_restore", int'(status_restore), m_rst);
    endtask

    task automatic cyc(bit iss, int o, int tg, int pg, bit sk, int a, int s);
        issue = iss; op = o[2:0]; target = tg[13:0]; rom_page = pg[1:0];
        skip_req = sk; acc_in = a[7:0]; status_in = s[7:0];
        @(posedge clk);
        model();
        @(negedge clk);
        compare();
    endtask

    initial begin
        // R1: reset state held across several edges
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 2, 14'h155, 1, 1, 0, 0);
        rst_n = 1'b1;
        // R2: plain steps, class 7, idle
        cur_req = "R2";
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 7, 0, 0, 1, 0, 0);
        cyc(0, 1, 14'h3FF, 3, 0, 0, 0);
        // R3 and R8: jump, then an ignored jump offered in the bubble
        cur_req = "R3";
        cyc(1, 1, 14'h1234, 2, 0, 0, 0);
        cur_req = "R8";
        cyc(1, 1, 14'h0001, 3, 0, 0, 0);
        cur_req = "R3";
        cyc(1, 1, 14'h3FFF, 3, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R2: step wraps from FFFF to 0
        cur_req = "R2";
        cyc(1, 0, 0, 0, 0, 0, 0);
        // R4 and R5: nested calls on different pages, then returns
        cur_req = "R4";
        cyc(1, 2, 14'h0100, 0, 0, 0, 0);  cyc(1, 2, 14'h0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 2, 14'h2222, 1, 0, 0, 0);  cyc(1, 3, 0, 0, 0, 0, 0);
        cyc(1, 2, 14'h3333, 2, 0, 0, 0);  cyc(0, 0, 0, 0, 0, 0, 0);
        cur_req = "R5";
        for (int i = 0; i < 3; i++) begin
            cyc(1, 3, 0, 0, 0, 0, 0);
            cyc(1, 2, 14'h0777, 3, 0, 0, 0);  // R8: ignored in bubble
        end
        // R7: taken skip, skip with a jump, skip with a save
        cur_req = "R7";
        cyc(1, 0, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 1, 0, 0);
        cyc(1, 1, 14'h0040, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 5, 0, 0, 1, 8'h11, 8'h22);
        // R11: save then restore with protected bits from live status
        cur_req = "R11";
        cyc(1, 5, 0, 0, 0, 8'h5A, 8'hFF);
        cyc(1, 0, 0, 0, 0, 8'h00, 8'h00);
        cyc(1, 6, 0, 0, 0, 8'h00, 8'h00);
        cyc(1, 6, 0, 0, 0, 8'h00, 8'h18);
        cyc(1, 0, 0, 0, 0, 0, 0);
        // R6: call then interrupt return enables gie
        cur_req = "R6";
        cyc(1, 2, 14'h0ABC, 1, 0, 0, 0);  cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 4, 0, 0, 0, 0, 0);         cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        // R10: nine calls overflow the eight-entry stack
        cur_req = "R10";
        for (int i = 0; i < 9; i++) begin
            cyc(1, 2, 14'h0010 + i, i % 4, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 0, 0);
        end
        // R9: returns run past empty, pointer keeps wrapping
        cur_req = "R9";
        for (int i = 0; i < 11; i++) begin
            cyc(1, 3, 0, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 0, 0);
        end
        // R2..R11 mixed: pseudo-random traffic
        cur_req = "R8";
        for (int i = 0; i < 600; i++)
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 16383),
                $urandom_range(0, 3), $urandom_range(0, 2) == 0,
                $urandom_range(0, 255), $urandom_range(0, 255));
        // R1: reset again from a busy state
        cur_req = "R1";
        rst_n = 1'b0;
        cyc(1, 4, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL R2 watchdog actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule